// File: doc/BRIEF.md
# Bus-Watch Debug Trigger Unit

This block sits beside a CPU bus and decides when a trace capture starts or stops. Two programmable comparators, A and B, are checked against every valid bus cycle. A four-bit mode field picks how their results combine into a trigger. A begin/end select decides whether the trigger opens or closes the capture window. A tag select can require that the matched cycle was an executed opcode, which the CPU pipeline reports on a qualifier input.

A small circular capture buffer keeps bus addresses, or bus data in the event-driven modes. Software programs the control word and comparators while the unit is idle, arms it, and then watches the status outputs. When the capture finishes the unit disarms by itself, and the buffer can then be read back oldest entry first.

Top module: `bus_trigger_unit`

## Requirements
- R1: After reset the control readback, the armed, triggered, A-seen and B-seen flags and the buffer count are all zero.
- R2: The configuration port selects a target with cfgSel: 0 is the control word (bits 3:0 mode, bit 6 begin select, bit 7 tag select), 1 is comparator A and 2 is comparator B. ctrlRd always returns {tag, begin, 2'b00, mode}, so bits 5:4 read 0. Writes to targets 0, 1 and 2 are ignored while the unit is armed.
- R3: Writing cfgSel 3 with data bit 0 set arms the unit and clears the triggered flag, the A-then-B memory, both seen flags and the buffer; writing it with bit 0 clear disarms. Bus cycles in an arm-write cycle are ignored.
- R4: Mode 0 fires on an A address match and mode 1 on an A or B address match.
- R5: Modes 2 and 4 fire on a B address match only after an A match in an earlier cycle of the same armed run.
- R6: Mode 5 fires when the address matches A and the bus data equals comparator B; mode 6 when the address matches A and the data differs from B.
- R7: Mode 7 fires when A <= address <= B; mode 8 when the address is below A or above B.
- R8: Mode codes 9 to 15 never fire and never set the triggered flag.
- R9: With tag select set, a bus cycle can only produce a match or trigger when opExec is high in that cycle; with it clear, opExec is ignored.
- R10: In begin trace (begin select 1, modes other than 3 and 4) the address of every valid bus cycle from the trigger cycle on is stored; the unit disarms when the buffer holds 8 entries.
- R11: In end trace (begin select 0, modes other than 3 and 4) every valid bus address is stored, the oldest being overwritten when 8 are held; the trigger cycle's address is stored and the unit disarms on that cycle.
- R12: In modes 3 and 4 the begin select is ignored: the bus data of each firing cycle is stored, the first firing sets the triggered flag, and the unit disarms when 8 entries are held.
- R13: fifoCount reports the number of held entries (0 to 8) and rdData returns entry rdIdx counted from the oldest.
- R14: While armed, the A-seen flag latches any qualified A address match; the B-seen flag latches a qualified data match with B in modes 5 and 6 and a qualified B address match in all other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target select |
| cfgWrData | input | W | Configuration write data |
| ctrlRd | output | 8 | Control word readback |
| busValid | input | 1 | Bus cycle valid |
| busAddr | input | W | Bus address |
| busData | input | W | Bus data |
| opExec | input | 1 | Executed-opcode qualifier from the pipeline |
| statArmed | output | 1 | Unit armed |
| statTrig | output | 1 | Trigger has fired in this run |
| statASeen | output | 1 | Comparator A has matched in this run |
| statBSeen | output | 1 | Comparator B has matched in this run |
| fifoCount | output | CW | Held buffer entries |
| rdIdx | input | PW | Buffer read index, 0 is oldest |
| rdData | output | W | Buffer entry at rdIdx |

## Verification
The assertions assume that the control word stays fixed for a whole armed run and that a trigger never appears while the unit is idle. Both follow from the write gating, and the stimulus also avoids configuration writes during a run except the deliberate ignored-write cases. The bus stimulus keeps comparator A below comparator B so that the range modes have a non-empty window, and it draws addresses and data close to the comparator values so that hits, misses and both range edges all occur.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam logic [3:0] MD_A        = 4'd0;
  localparam logic [3:0] MD_A_OR_B   = 4'd1;
  localparam logic [3:0] MD_A_THEN_B = 4'd2;
  localparam logic [3:0] MD_EV_B     = 4'd3;
  localparam logic [3:0] MD_A_EV_B   = 4'd4;
  localparam logic [3:0] MD_DATA_EQ  = 4'd5;
  localparam logic [3:0] MD_DATA_NE  = 4'd6;
  localparam logic [3:0] MD_INSIDE   = 4'd7;
  localparam logic [3:0] MD_OUTSIDE  = 4'd8;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CMPA = 2'd1;
  localparam logic [1:0] SEL_CMPB = 2'd2;
  localparam logic [1:0] SEL_ARM  = 2'd3;

  // control to datapath
  typedef struct packed {
    logic clearFifo;
    logic push;
    logic pushData;
    logic wrA;
    logic wrB;
  } strobe_t;

  // datapath to control
  typedef struct packed {
    logic aHit;
    logic bAddrHit;
    logic bDataHit;
    logic geA;
    logic leB;
  } hits_t;

endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [W-1:0]  cfgWrData,
  input  logic [W-1:0]  busAddr,
  input  logic [W-1:0]  busData,
  output hits_t         hits,
  input  logic [PW-1:0] rdIdx,
  output logic [W-1:0]  rdData,
  output logic [CW-1:0] count
);

  logic [W-1:0]  cmpA;
  logic [W-1:0]  cmpB;
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [W-1:0]  pushVal;
  logic [31:0]   slotSum;
  logic [PW-1:0] slot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpA <= '0;
      cmpB <= '0;
    end else begin
      if (strb.wrA) cmpA <= cfgWrData;
      if (strb.wrB) cmpB <= cfgWrData;
    end
  end

  always_comb begin
    hits.aHit     = (busAddr == cmpA);
    hits.bAddrHit = (busAddr == cmpB);
    hits.bDataHit = (busData == cmpB);
    hits.geA      = (busAddr >= cmpA);
    hits.leB      = (busAddr <= cmpB);
  end

  assign pushVal = strb.pushData ? busData : busAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      count <= '0;
    end else if (strb.clearFifo) begin
      wrPtr <= '0;
      count <= '0;
    end else if (strb.push) begin
      wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (count != CW'(DEPTH)) count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push && !strb.clearFifo) mem[wrPtr] <= pushVal;
  end

  // oldest entry sits count slots behind the write pointer
  always_comb begin
    slotSum = 32'(wrPtr) + 32'(DEPTH) - 32'(count) + 32'(rdIdx);
    slot    = PW'(slotSum % 32'(DEPTH));
    rdData  = mem[slot];
  end

  // R13
  count_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R13
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.clearFifo && count < CW'(DEPTH)) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [1:0]    cfgSel,
  input  logic [7:0]    cfgByte,
  input  logic          busValid,
  input  logic          opExec,
  input  hits_t         hits,
  input  logic [CW-1:0] count,
  output strobe_t       strb,
  output logic [7:0]    ctrlRd,
  output logic          armed,
  output logic          triggered,
  output logic          aSeen,
  output logic          bSeen
);

  logic [3:0] modeQ;
  logic       beginQ;
  logic       tagQ;
  logic       seqQ;

  logic armWr, armStart, cfgOpen, live, qual;
  logic aQ, bQ, bSeenHit, inRange, evOnly, beginEff, fire, push, done;

  assign armWr    = cfgWrEn && (cfgSel == SEL_ARM);
  assign armStart = armWr && cfgByte[0];
  assign cfgOpen  = cfgWrEn && !armed;
  assign live     = armed && busValid && !armWr;
  assign qual     = tagQ ? opExec : 1'b1;
  assign aQ       = live && qual && hits.aHit;
  assign bQ       = live && qual && hits.bAddrHit;
  assign inRange  = hits.geA && hits.leB;
  assign evOnly   = (modeQ == MD_EV_B) || (modeQ == MD_A_EV_B);
  assign beginEff = beginQ || evOnly;

  always_comb begin
    unique case (modeQ)
      MD_A:        fire = aQ;
      MD_A_OR_B:   fire = aQ || bQ;
      MD_A_THEN_B: fire = seqQ && bQ;
      MD_EV_B:     fire = bQ;
      MD_A_EV_B:   fire = seqQ && bQ;
      MD_DATA_EQ:  fire = aQ && hits.bDataHit;
      MD_DATA_NE:  fire = aQ && !hits.bDataHit;
      MD_INSIDE:   fire = live && qual && inRange;
      MD_OUTSIDE:  fire = live && qual && !inRange;
      default:     fire = 1'b0;
    endcase
  end

  always_comb begin
    if ((modeQ == MD_DATA_EQ) || (modeQ == MD_DATA_NE))
      bSeenHit = live && qual && hits.bDataHit;
    else
      bSeenHit = bQ;
  end

  always_comb begin
    if (evOnly)       push = fire;
    else if (beginQ)  push = live && (triggered || fire);
    else              push = live;
  end

  always_comb begin
    if (beginEff) done = push && (count == CW'(DEPTH - 1));
    else          done = fire;
  end

  always_comb begin
    strb.clearFifo = armStart;
    strb.push      = push;
    strb.pushData  = evOnly;
    strb.wrA       = cfgOpen && (cfgSel == SEL_CMPA);
    strb.wrB       = cfgOpen && (cfgSel == SEL_CMPB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= '0;
      beginQ <= 1'b0;
      tagQ   <= 1'b0;
    end else if (cfgOpen && (cfgSel == SEL_CTRL)) begin
      modeQ  <= cfgByte[3:0];
      beginQ <= cfgByte[6];
      tagQ   <= cfgByte[7];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      triggered <= 1'b0;
      seqQ      <= 1'b0;
      aSeen     <= 1'b0;
      bSeen     <= 1'b0;
    end else if (armStart) begin
      armed     <= 1'b1;
      triggered <= 1'b0;
      seqQ      <= 1'b0;
      aSeen     <= 1'b0;
      bSeen     <= 1'b0;
    end else if (armWr) begin
      armed <= 1'b0;
    end else if (live) begin
      if (fire)     triggered <= 1'b1;
      if (aQ)       seqQ      <= 1'b1;
      if (aQ)       aSeen     <= 1'b1;
      if (bSeenHit) bSeen     <= 1'b1;
      if (done)     armed     <= 1'b0;
    end
  end

  assign ctrlRd = {tagQ, beginQ, 2'b00, modeQ};

  // R2
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> $stable(ctrlRd));

  // R8
  dead_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && modeQ > MD_OUTSIDE && !triggered) |=> !triggered);

  // R5
  seq_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(triggered) && (modeQ == MD_A_THEN_B || modeQ == MD_A_EV_B)) |-> $past(seqQ));

  // R11
  end_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(triggered) && !beginQ && !evOnly) |-> !armed);

endmodule

// File: rtl/bus_trigger_unit.sv
module bus_trigger_unit
  import trig_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [1:0]    cfgSel,
  input  logic [W-1:0]  cfgWrData,
  output logic [7:0]    ctrlRd,
  input  logic          busValid,
  input  logic [W-1:0]  busAddr,
  input  logic [W-1:0]  busData,
  input  logic          opExec,
  output logic          statArmed,
  output logic          statTrig,
  output logic          statASeen,
  output logic          statBSeen,
  output logic [CW-1:0] fifoCount,
  input  logic [PW-1:0] rdIdx,
  output logic [W-1:0]  rdData
);

  strobe_t strb;
  hits_t   hits;

  trig_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgByte   (cfgWrData[7:0]),
    .busValid  (busValid),
    .opExec    (opExec),
    .hits      (hits),
    .count     (fifoCount),
    .strb      (strb),
    .ctrlRd    (ctrlRd),
    .armed     (statArmed),
    .triggered (statTrig),
    .aSeen     (statASeen),
    .bSeen     (statBSeen)
  );

  trig_datapath #(.W(W), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgWrData (cfgWrData),
    .busAddr   (busAddr),
    .busData   (busData),
    .hits      (hits),
    .rdIdx     (rdIdx),
    .rdData    (rdData),
    .count     (fifoCount)
  );

endmodule

// File: tb/bus_trigger_unit_test.sv
module bus_trigger_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [W-1:0] cfgWrData = '0;
  logic [7:0] ctrlRd;
  logic busValid = 1'b0;
  logic [W-1:0] busAddr = '0;
  logic [W-1:0] busData = '0;
  logic opExec = 1'b0;
  logic statArmed, statTrig, statASeen, statBSeen;
  logic [3:0] fifoCount;
  logic [2:0] rdIdx = '0;
  logic [W-1:0] rdData;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // model state
  logic [3:0] mMode = '0;
  logic mBegin = 0, mTag = 0, mArmed = 0, mTrig = 0, mSeq = 0, mA = 0, mB = 0;
  logic [W-1:0] mCmpA = '0, mCmpB = '0;
  logic [W-1:0] mFifo [DEPTH];
  int mCount = 0;

  bus_trigger_unit uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string reqOfMode(logic [3:0] md, logic tg);
    if (tg) return "R9";
    case (md)
      4'd0, 4'd1: return "R4";
      4'd2, 4'd4: return "R5";
      4'd3:       return "R12";
      4'd5, 4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      default:    return "R8";
    endcase
  endfunction

  function automatic logic modelFire(logic aQ, logic bQ, logic dEq, logic lq, logic inR);
    case (mMode)
      4'd0: return aQ;
      4'd1: return aQ | bQ;
      4'd2, 4'd4: return mSeq & bQ;
      4'd3: return bQ;
      4'd5: return aQ & dEq;
      4'd6: return aQ & ~dEq;
      4'd7: return lq & inR;
      4'd8: return lq & ~inR;
      default: return 1'b0;
    endcase
  endfunction

  task automatic modelPush(logic [W-1:0] v);
    if (mCount < DEPTH) begin
      mFifo[mCount] = v;
      mCount++;
    end else begin
      for (int i = 0; i < DEPTH - 1; i++) mFifo[i] = mFifo[i+1];
      mFifo[DEPTH-1] = v;
    end
  endtask

  // one clock: update the model from the applied inputs, then compare
  task automatic cycle();
    logic armWr, live, lq, aQ, bQ, dEq, inR, ev, fire, push, done, bHit;
    armWr = cfgWrEn && cfgSel == 2'd3;
    live = mArmed && busValid && !armWr;
    lq = live && (!mTag || opExec);
    aQ = lq && busAddr == mCmpA;
    bQ = lq && busAddr == mCmpB;
    dEq = busData == mCmpB;
    inR = busAddr >= mCmpA && busAddr <= mCmpB;
    ev = mMode == 4'd3 || mMode == 4'd4;
    fire = modelFire(aQ, bQ, dEq, lq, inR);
    bHit = (mMode == 4'd5 || mMode == 4'd6) ? (lq && dEq) : bQ;
    if (ev) push = fire;
    else if (mBegin) push = live && (mTrig || fire);
    else push = live;
    done = (mBegin || ev) ? (push && mCount == DEPTH - 1) : fire;
    if (cfgWrEn && !mArmed) begin
      case (cfgSel)
        2'd0: begin mMode = cfgWrData[3:0]; mBegin = cfgWrData[6]; mTag = cfgWrData[7]; end
        2'd1: mCmpA = cfgWrData;
        2'd2: mCmpB = cfgWrData;
        default: ;
      endcase
    end
    if (armWr) begin
      if (cfgWrData[0]) begin
        mArmed = 1; mTrig = 0; mSeq = 0; mA = 0; mB = 0; mCount = 0;
      end else mArmed = 0;
    end else if (live) begin
      if (push) modelPush(ev ? busData : busAddr);
      if (fire) mTrig = 1;
      if (aQ) begin mSeq = 1; mA = 1; end
      if (bHit) mB = 1;
      if (done) mArmed = 0;
    end
    @(posedge clk);
    #1;
    check(reqOfMode(mMode, mTag), 32'(statTrig), 32'(mTrig));
    check((mBegin || ev) ? "R10" : "R11", 32'(statArmed), 32'(mArmed));
    check("R14", 32'({statASeen, statBSeen}), 32'({mA, mB}));
    check("R13", 32'(fifoCount), 32'(mCount));
  endtask

  task automatic idle();
    cfgWrEn = 0; busValid = 0; opExec = 0;
  endtask

  task automatic cfgWrite(logic [1:0] sel, logic [W-1:0] d);
    idle();
    cfgWrEn = 1; cfgSel = sel; cfgWrData = d;
    cycle();
    cfgWrEn = 0;
  endtask

  task automatic busCycle(logic [W-1:0] a, logic [W-1:0] d, logic ex);
    cfgWrEn = 0; busValid = 1; busAddr = a; busData = d; opExec = ex;
    cycle();
    idle();
  endtask

  task automatic checkFifo(string req);
    for (int i = 0; i < mCount; i++) begin
      rdIdx = 3'(i);
      #1;
      check(req, 32'(rdData), 32'(mFifo[i]));
    end
  endtask

  task automatic randomRun(logic [3:0] md, logic bg, logic tg);
    logic [W-1:0] a, b, ad, dt;
    int pick;
    a = W'(16'h0110 + $urandom_range(0, 48));
    b = W'(16'h0150 + $urandom_range(0, 48));
    cfgWrite(2'd3, '0);
    cfgWrite(2'd0, W'({tg, bg, 2'b00, md}));
    cfgWrite(2'd1, a);
    cfgWrite(2'd2, b);
    cfgWrite(2'd3, W'(1));
    check("R3", 32'({statArmed, statTrig, statASeen, statBSeen, fifoCount}), 32'({4'b1000, 4'd0}));
    for (int c = 0; c < 40; c++) begin
      pick = $urandom_range(0, 5);
      case (pick)
        0: ad = a;
        1: ad = b;
        2: ad = a - 1'b1;
        3: ad = b + 1'b1;
        default: ad = W'(16'h0100 + $urandom_range(0, 160));
      endcase
      dt = ($urandom_range(0, 1) == 0) ? b : W'($urandom);
      busValid = ($urandom_range(0, 3) != 0);
      busAddr = ad; busData = dt; opExec = $urandom_range(0, 1) == 1;
      cfgWrEn = 0;
      cycle();
    end
    idle();
    checkFifo((bg || md == 4'd3 || md == 4'd4) ? ((md == 4'd3 || md == 4'd4) ? "R12" : "R10") : "R11");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mFifo[i] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    // R1 reset state
    check("R1", 32'({ctrlRd, statArmed, statTrig, statASeen, statBSeen, fifoCount}), 32'(0));

    // R2 bits 5:4 read zero
    cfgWrite(2'd0, W'(8'hF2));
    check("R2", 32'(ctrlRd), 32'(8'hC2));

    // R5 A and B in the same cycle does not fire; A then B does
    cfgWrite(2'd0, W'(8'h02));
    cfgWrite(2'd1, W'(16'h0200));
    cfgWrite(2'd2, W'(16'h0200));
    cfgWrite(2'd3, W'(1));
    busCycle(16'h0200, 16'h0, 1'b0);
    check("R5", 32'(statTrig), 32'(0));
    busCycle(16'h0200, 16'h0, 1'b0);
    check("R5", 32'({statTrig, statArmed}), 32'(2'b10));

    // R2 writes ignored while armed; R3 arm-write cycle ignores bus
    cfgWrite(2'd0, W'(8'h00));
    cfgWrite(2'd1, W'(16'h0300));
    cfgWrite(2'd2, W'(16'h0300));
    cfgWrite(2'd3, W'(1));
    cfgWrite(2'd0, W'(8'hFF));
    check("R2", 32'(ctrlRd), 32'(8'h00));
    cfgWrite(2'd1, W'(16'h0400));
    busCycle(16'h0400, 16'h0, 1'b0);
    check("R2", 32'(statTrig), 32'(0));
    cfgWrEn = 1; cfgSel = 2'd3; cfgWrData = W'(1);
    busValid = 1; busAddr = 16'h0300;
    cycle();
    idle();
    check("R3", 32'(statTrig), 32'(0));
    busCycle(16'h0300, 16'h0, 1'b0);
    check("R4", 32'(statTrig), 32'(1));

    // R8 dead mode, R10/R11/R12 via random runs with R9 tag qualification
    for (int md = 0; md < 12; md++)
      for (int bg = 0; bg < 2; bg++)
        for (int tg = 0; tg < 2; tg++)
          randomRun(4'(md), bg[0], tg[0]);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule